// File: doc/BRIEF.md
# Issue Busy-Timer Reservation

This block keeps the occupancy of shared issue resources in a compute unit up to date once an instruction has been dispatched. It holds a set of down-counting busy timers. Each SIMD has one ALU pipeline timer. Each execution unit has one issue-slot timer: the SIMDs, then a global memory unit, then a shared memory unit. It also holds two pools of operand buses, one from the register file to global memory and one from the register file to local memory. A timer that has counted down to zero reports its resource as free.

A scheduler drives one issue pulse per cycle. The pulse carries an instruction kind, the issuing SIMD and, for flat accesses, the resolved address space. The block decodes the kind and loads the matching timers. For memory kinds it picks the next bus in the chosen pool in round-robin order and raises the in-pipe request counters. Execution itself and the memory pipelines lie outside the block.

Top module: `issue_rsv_timers`

## Requirements
- R1: After reset every ready output is 1 and all five in-pipe counters are 0.
- R2: Kinds 1 to 6 (ALU, branch, return, special, kernel argument, segment address) load the ALU timer of `issueSimd` with BYPASS_LEN (default 5). They also load that SIMD's issue-slot timer with ISSUE_PERIOD (default 3). Each ready output goes low on the issue edge and stays low for exactly that many cycles.
- R3: Kind 7 (barrier) loads only the issuing SIMD's issue-slot timer with ISSUE_PERIOD. The ALU timers and the buses are left untouched.
- R4: Global kinds 8 to 10 and private kinds 14 to 16 reserve one global bus. Reads (8 and 14) hold it for RD_HOLD (4) cycles. Writes and atomics (9, 10, 15 and 16) hold it for WR_HOLD (8) cycles. These kinds also load the global unit's slot timer (slot index NUM_SIMD) with ISSUE_PERIOD.
- R5: Local kinds 11 to 13 (read, write, atomic) reserve one local bus with the same read and write lengths. They also load the shared unit's slot timer (slot index NUM_SIMD+1).
- R6: Flat kinds 17 (read) and 18 (write) use the local bus pool and the shared slot when `flatSpace` is 2. When `flatSpace` is 1 or 3 they use the global pool and the global slot.
- R7: A flat kind with `flatSpace` 0 raises `flatErr` in the same cycle. It reserves no timer, leaves the bus pointers alone and changes no counter.
- R8: Each pool picks its buses in round-robin order from index 0, and the pointer advances only on a reservation in that pool.
- R9: Global and private reads and flat reads add 1 to `glbRdInPipe`. Their writes, including flat writes, add 1 to `glbWrInPipe`. Their atomics add 1 to both. Local reads, writes and atomics do the same to `locRdInPipe` and `locWrInPipe`. Every memory issue adds 1 to `memInPipe`.
- R10: A load in the same cycle that a timer would count down wins: the timer restarts at the full length.
- R11: Kind 0 (no-op) and the codes 19 to 31 change no timer, pointer or counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| issueValid | input | 1 | Issue pulse, one instruction per cycle |
| issueKind | input | 5 | Instruction kind code |
| issueSimd | input | SIMD_W | Issuing SIMD index |
| flatSpace | input | 2 | Resolved space for flat kinds: 0 none, 1 global, 2 shared, 3 global |
| flatErr | output | 1 | Flat issue with no resolved space (combinational) |
| aluRdy | output | NUM_SIMD | ALU pipeline timer is zero, one bit per SIMD |
| slotRdy | output | NUM_SIMD+2 | Issue-slot timer is zero: SIMDs, then global unit, then shared unit |
| glbBusRdy | output | NUM_GLB_BUS | Register-file-to-global bus is free |
| locBusRdy | output | NUM_LOC_BUS | Register-file-to-local bus is free |
| memInPipe | output | CNT_W | Total memory requests issued |
| glbRdInPipe | output | CNT_W | Global-side read requests issued |
| glbWrInPipe | output | CNT_W | Global-side write requests issued |
| locRdInPipe | output | CNT_W | Local read requests issued |
| locWrInPipe | output | CNT_W | Local write requests issued |

## Verification
A reload and a countdown can land on the same timer in the same cycle. The bench provokes this by issuing three global writes on three consecutive edges with two buses. Round-robin selection then returns the third write to the first bus two cycles into its hold. That bus's ready output must then stay low for a full WR_HOLD cycles counted from the third edge, not for the remainder of the first hold. The same burst reloads the global slot timer on every edge, and the bus pointer and counters must show all three reservations.

// File: rtl/issue_rsv_pkg.sv
package issue_rsv_pkg;

  localparam logic [4:0] K_NOP     = 5'd0;
  localparam logic [4:0] K_ALU     = 5'd1;
  localparam logic [4:0] K_BRANCH  = 5'd2;
  localparam logic [4:0] K_RET     = 5'd3;
  localparam logic [4:0] K_SPECIAL = 5'd4;
  localparam logic [4:0] K_KERNARG = 5'd5;
  localparam logic [4:0] K_SEGADDR = 5'd6;
  localparam logic [4:0] K_BARRIER = 5'd7;
  localparam logic [4:0] K_GLB_RD  = 5'd8;
  localparam logic [4:0] K_GLB_WR  = 5'd9;
  localparam logic [4:0] K_GLB_AT  = 5'd10;
  localparam logic [4:0] K_LOC_RD  = 5'd11;
  localparam logic [4:0] K_LOC_WR  = 5'd12;
  localparam logic [4:0] K_LOC_AT  = 5'd13;
  localparam logic [4:0] K_PRV_RD  = 5'd14;
  localparam logic [4:0] K_PRV_WR  = 5'd15;
  localparam logic [4:0] K_PRV_AT  = 5'd16;
  localparam logic [4:0] K_FLAT_RD = 5'd17;
  localparam logic [4:0] K_FLAT_WR = 5'd18;

  localparam logic [1:0] SPACE_NONE   = 2'd0;
  localparam logic [1:0] SPACE_SHARED = 2'd2;

  typedef enum logic [1:0] {SLOT_NONE, SLOT_SIMD, SLOT_GLB, SLOT_LOC} slot_sel_e;
  typedef enum logic [1:0] {POOL_NONE, POOL_GLB, POOL_LOC} pool_sel_e;

  typedef struct packed {
    logic      loadAlu;
    slot_sel_e slotSel;
    pool_sel_e pool;
    logic      longHold;
    logic      incGlbRd;
    logic      incGlbWr;
    logic      incLocRd;
    logic      incLocWr;
  } rsv_strobe_t;

endpackage

// File: rtl/busy_timer.sv
module busy_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  output logic         rdy
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (load)        cnt <= loadVal;
    else if (cnt != '0)   cnt <= cnt - W'(1);
  end

  assign rdy = (cnt == '0);

  // R10
  load_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    load |=> (cnt == $past(loadVal)));

  // R2
  countdown_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - W'(1)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!load && rdy) |=> rdy);

endmodule

// File: rtl/issue_rsv_ctrl.sv
module issue_rsv_ctrl
  import issue_rsv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        issueValid,
  input  logic [4:0]  issueKind,
  input  logic [1:0]  flatSpace,
  output rsv_strobe_t strobe,
  output logic        flatErr
);

  pool_sel_e flatPool;
  slot_sel_e flatSlot;

  always_comb begin
    flatPool = (flatSpace == SPACE_SHARED) ? POOL_LOC : POOL_GLB;
    flatSlot = (flatSpace == SPACE_SHARED) ? SLOT_LOC : SLOT_GLB;
  end

  always_comb begin
    strobe  = '0;
    flatErr = 1'b0;
    if (issueValid) begin
      case (issueKind)
        K_ALU, K_BRANCH, K_RET, K_SPECIAL, K_KERNARG, K_SEGADDR: begin
          strobe.loadAlu = 1'b1;
          strobe.slotSel = SLOT_SIMD;
        end
        K_BARRIER: strobe.slotSel = SLOT_SIMD;
        K_GLB_RD, K_PRV_RD: begin
          strobe.pool     = POOL_GLB;
          strobe.slotSel  = SLOT_GLB;
          strobe.incGlbRd = 1'b1;
        end
        K_GLB_WR, K_PRV_WR: begin
          strobe.pool     = POOL_GLB;
          strobe.slotSel  = SLOT_GLB;
          strobe.longHold = 1'b1;
          strobe.incGlbWr = 1'b1;
        end
        K_GLB_AT, K_PRV_AT: begin
          strobe.pool     = POOL_GLB;
          strobe.slotSel  = SLOT_GLB;
          strobe.longHold = 1'b1;
          strobe.incGlbRd = 1'b1;
          strobe.incGlbWr = 1'b1;
        end
        K_LOC_RD: begin
          strobe.pool     = POOL_LOC;
          strobe.slotSel  = SLOT_LOC;
          strobe.incLocRd = 1'b1;
        end
        K_LOC_WR: begin
          strobe.pool     = POOL_LOC;
          strobe.slotSel  = SLOT_LOC;
          strobe.longHold = 1'b1;
          strobe.incLocWr = 1'b1;
        end
        K_LOC_AT: begin
          strobe.pool     = POOL_LOC;
          strobe.slotSel  = SLOT_LOC;
          strobe.longHold = 1'b1;
          strobe.incLocRd = 1'b1;
          strobe.incLocWr = 1'b1;
        end
        K_FLAT_RD, K_FLAT_WR: begin
          if (flatSpace == SPACE_NONE) begin
            flatErr = 1'b1;
          end else begin
            strobe.pool     = flatPool;
            strobe.slotSel  = flatSlot;
            strobe.longHold = (issueKind == K_FLAT_WR);
            strobe.incGlbRd = (issueKind == K_FLAT_RD);
            strobe.incGlbWr = (issueKind == K_FLAT_WR);
          end
        end
        default: ;
      endcase
    end
  end

  // R7
  flat_none_chk: assert property (@(posedge clk) disable iff (!rstN)
    flatErr |-> (strobe.pool == POOL_NONE && !strobe.loadAlu &&
                 strobe.slotSel == SLOT_NONE));

  // R3
  barrier_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueKind == K_BARRIER) |-> (!strobe.loadAlu && strobe.pool == POOL_NONE));

endmodule

// File: rtl/issue_rsv_dp.sv
module issue_rsv_dp
  import issue_rsv_pkg::*;
#(
  parameter int NUM_SIMD     = 2,
  parameter int NUM_GLB_BUS  = 2,
  parameter int NUM_LOC_BUS  = 2,
  parameter int BYPASS_LEN   = 5,
  parameter int ISSUE_PERIOD = 3,
  parameter int RD_HOLD      = 4,
  parameter int WR_HOLD      = 8,
  parameter int CNT_W        = 8,
  parameter int SIMD_W       = (NUM_SIMD > 1) ? $clog2(NUM_SIMD) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  rsv_strobe_t            strobe,
  input  logic [SIMD_W-1:0]      issueSimd,
  output logic [NUM_SIMD-1:0]    aluRdy,
  output logic [NUM_SIMD+1:0]    slotRdy,
  output logic [NUM_GLB_BUS-1:0] glbBusRdy,
  output logic [NUM_LOC_BUS-1:0] locBusRdy,
  output logic [CNT_W-1:0]       memInPipe,
  output logic [CNT_W-1:0]       glbRdInPipe,
  output logic [CNT_W-1:0]       glbWrInPipe,
  output logic [CNT_W-1:0]       locRdInPipe,
  output logic [CNT_W-1:0]       locWrInPipe
);

  localparam int MAX_A  = (BYPASS_LEN > ISSUE_PERIOD) ? BYPASS_LEN : ISSUE_PERIOD;
  localparam int MAX_B  = (RD_HOLD > WR_HOLD) ? RD_HOLD : WR_HOLD;
  localparam int MAX_L  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TMR_W  = $clog2(MAX_L + 1);
  localparam int NUM_SLOT = NUM_SIMD + 2;
  localparam int GLB_SLOT = NUM_SIMD;
  localparam int LOC_SLOT = NUM_SIMD + 1;
  localparam int GPTR_W = (NUM_GLB_BUS > 1) ? $clog2(NUM_GLB_BUS) : 1;
  localparam int LPTR_W = (NUM_LOC_BUS > 1) ? $clog2(NUM_LOC_BUS) : 1;

  logic [NUM_SIMD-1:0]    aluLoad;
  logic [NUM_SLOT-1:0]    slotLoad;
  logic [NUM_GLB_BUS-1:0] glbLoad;
  logic [NUM_LOC_BUS-1:0] locLoad;
  logic [GPTR_W-1:0]      glbPtr;
  logic [LPTR_W-1:0]      locPtr;
  logic [TMR_W-1:0]       busLen;
  logic                   anyMem;

  assign busLen = strobe.longHold ? TMR_W'(WR_HOLD) : TMR_W'(RD_HOLD);
  assign anyMem = (strobe.pool != POOL_NONE);

  always_comb begin
    for (int i = 0; i < NUM_SIMD; i++) begin
      aluLoad[i]  = strobe.loadAlu && (issueSimd == SIMD_W'(i));
      slotLoad[i] = (strobe.slotSel == SLOT_SIMD) && (issueSimd == SIMD_W'(i));
    end
    slotLoad[GLB_SLOT] = (strobe.slotSel == SLOT_GLB);
    slotLoad[LOC_SLOT] = (strobe.slotSel == SLOT_LOC);
    for (int g = 0; g < NUM_GLB_BUS; g++)
      glbLoad[g] = (strobe.pool == POOL_GLB) && (glbPtr == GPTR_W'(g));
    for (int l = 0; l < NUM_LOC_BUS; l++)
      locLoad[l] = (strobe.pool == POOL_LOC) && (locPtr == LPTR_W'(l));
  end

  generate
    for (genvar a = 0; a < NUM_SIMD; a++) begin : g_alu
      busy_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rstN(rstN), .load(aluLoad[a]),
        .loadVal(TMR_W'(BYPASS_LEN)), .rdy(aluRdy[a]));
    end
    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
      busy_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rstN(rstN), .load(slotLoad[s]),
        .loadVal(TMR_W'(ISSUE_PERIOD)), .rdy(slotRdy[s]));
    end
    for (genvar g = 0; g < NUM_GLB_BUS; g++) begin : g_gbus
      busy_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rstN(rstN), .load(glbLoad[g]),
        .loadVal(busLen), .rdy(glbBusRdy[g]));
    end
    for (genvar l = 0; l < NUM_LOC_BUS; l++) begin : g_lbus
      busy_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rstN(rstN), .load(locLoad[l]),
        .loadVal(busLen), .rdy(locBusRdy[l]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      glbPtr <= '0;
      locPtr <= '0;
    end else begin
      if (strobe.pool == POOL_GLB)
        glbPtr <= (glbPtr == GPTR_W'(NUM_GLB_BUS - 1)) ? '0 : glbPtr + GPTR_W'(1);
      if (strobe.pool == POOL_LOC)
        locPtr <= (locPtr == LPTR_W'(NUM_LOC_BUS - 1)) ? '0 : locPtr + LPTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memInPipe   <= '0;
      glbRdInPipe <= '0;
      glbWrInPipe <= '0;
      locRdInPipe <= '0;
      locWrInPipe <= '0;
    end else begin
      if (anyMem)          memInPipe   <= memInPipe + CNT_W'(1);
      if (strobe.incGlbRd) glbRdInPipe <= glbRdInPipe + CNT_W'(1);
      if (strobe.incGlbWr) glbWrInPipe <= glbWrInPipe + CNT_W'(1);
      if (strobe.incLocRd) locRdInPipe <= locRdInPipe + CNT_W'(1);
      if (strobe.incLocWr) locWrInPipe <= locWrInPipe + CNT_W'(1);
    end
  end

  // R8
  glb_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(glbLoad));

  // R8
  loc_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(locLoad));

  // R8
  glb_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pool != POOL_GLB) |=> $stable(glbPtr));

  // R9
  mem_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !anyMem |=> $stable(memInPipe));

  // R9
  mem_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyMem |=> (memInPipe == $past(memInPipe) + CNT_W'(1)));

endmodule

// File: rtl/issue_rsv_timers.sv
module issue_rsv_timers
  import issue_rsv_pkg::*;
#(
  parameter int NUM_SIMD     = 2,
  parameter int NUM_GLB_BUS  = 2,
  parameter int NUM_LOC_BUS  = 2,
  parameter int BYPASS_LEN   = 5,
  parameter int ISSUE_PERIOD = 3,
  parameter int RD_HOLD      = 4,
  parameter int WR_HOLD      = 8,
  parameter int CNT_W        = 8,
  parameter int SIMD_W       = (NUM_SIMD > 1) ? $clog2(NUM_SIMD) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   issueValid,
  input  logic [4:0]             issueKind,
  input  logic [SIMD_W-1:0]      issueSimd,
  input  logic [1:0]             flatSpace,
  output logic                   flatErr,
  output logic [NUM_SIMD-1:0]    aluRdy,
  output logic [NUM_SIMD+1:0]    slotRdy,
  output logic [NUM_GLB_BUS-1:0] glbBusRdy,
  output logic [NUM_LOC_BUS-1:0] locBusRdy,
  output logic [CNT_W-1:0]       memInPipe,
  output logic [CNT_W-1:0]       glbRdInPipe,
  output logic [CNT_W-1:0]       glbWrInPipe,
  output logic [CNT_W-1:0]       locRdInPipe,
  output logic [CNT_W-1:0]       locWrInPipe
);

  rsv_strobe_t strobe;

  issue_rsv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueKind(issueKind),
    .flatSpace(flatSpace), .strobe(strobe), .flatErr(flatErr));

  issue_rsv_dp #(
    .NUM_SIMD(NUM_SIMD), .NUM_GLB_BUS(NUM_GLB_BUS), .NUM_LOC_BUS(NUM_LOC_BUS),
    .BYPASS_LEN(BYPASS_LEN), .ISSUE_PERIOD(ISSUE_PERIOD), .RD_HOLD(RD_HOLD),
    .WR_HOLD(WR_HOLD), .CNT_W(CNT_W), .SIMD_W(SIMD_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .issueSimd(issueSimd),
    .aluRdy(aluRdy), .slotRdy(slotRdy), .glbBusRdy(glbBusRdy), .locBusRdy(locBusRdy),
    .memInPipe(memInPipe), .glbRdInPipe(glbRdInPipe), .glbWrInPipe(glbWrInPipe),
    .locRdInPipe(locRdInPipe), .locWrInPipe(locWrInPipe));

endmodule

// File: tb/sim_issue_rsv_timers.sv
`timescale 1ns/1ps
module sim_issue_rsv_timers;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       issueValid = 1'b0;
  logic [4:0] issueKind = 5'd0;
  logic [0:0] issueSimd = 1'b0;
  logic [1:0] flatSpace = 2'd0;
  logic       flatErr;
  logic [1:0] aluRdy;
  logic [3:0] slotRdy;
  logic [1:0] glbBusRdy;
  logic [1:0] locBusRdy;
  logic [7:0] memInPipe, glbRdInPipe, glbWrInPipe, locRdInPipe, locWrInPipe;

  always #2 clk = ~clk;

  issue_rsv_timers u0 (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueKind(issueKind),
    .issueSimd(issueSimd), .flatSpace(flatSpace), .flatErr(flatErr),
    .aluRdy(aluRdy), .slotRdy(slotRdy), .glbBusRdy(glbBusRdy), .locBusRdy(locBusRdy),
    .memInPipe(memInPipe), .glbRdInPipe(glbRdInPipe), .glbWrInPipe(glbWrInPipe),
    .locRdInPipe(locRdInPipe), .locWrInPipe(locWrInPipe));

  // bits: 0-1 ALU, 2-3 SIMD slots, 4 global slot, 5 shared slot, 6-7 global bus, 8-9 local bus
  wire [9:0] allRdy = {locBusRdy, glbBusRdy, slotRdy, aluRdy};

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int expLen[10];
  int gPtr = 0, lPtr = 0;
  int eMem = 0, eGr = 0, eGw = 0, eLr = 0, eLw = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] k, input int s, input logic [1:0] sp);
    @(negedge clk);
    issueValid = 1'b1; issueKind = k; issueSimd = 1'(s); flatSpace = sp;
    @(posedge clk); #1;
    issueValid = 1'b0;
  endtask

  // Bench model of the requirements: fills expLen and updates expected pointers/counters
  task automatic model(input logic [4:0] k, input int s, input logic [1:0] sp);
    int pool; bit lng;
    for (int b = 0; b < 10; b++) expLen[b] = 0;
    pool = 0; lng = 0;
    if (k >= 1 && k <= 6) begin expLen[s] = 5; expLen[2+s] = 3; end
    else if (k == 7) expLen[2+s] = 3;
    else if ((k >= 8 && k <= 10) || (k >= 14 && k <= 16)) begin
      pool = 1; lng = !(k == 8 || k == 14);
      if (k == 8 || k == 14) eGr++;
      else if (k == 9 || k == 15) eGw++;
      else begin eGr++; eGw++; end
    end else if (k >= 11 && k <= 13) begin
      pool = 2; lng = (k != 11);
      if (k == 11) eLr++; else if (k == 12) eLw++; else begin eLr++; eLw++; end
    end else if ((k == 17 || k == 18) && sp != 0) begin
      pool = (sp == 2) ? 2 : 1; lng = (k == 18);
      if (k == 17) eGr++; else eGw++;
    end
    if (pool == 1) begin
      expLen[6+gPtr] = lng ? 8 : 4; expLen[4] = 3; gPtr = (gPtr + 1) % 2; eMem++;
    end else if (pool == 2) begin
      expLen[8+lPtr] = lng ? 8 : 4; expLen[5] = 3; lPtr = (lPtr + 1) % 2; eMem++;
    end
  endtask

  task automatic window(input string req);
    bit ok = 1; int badT = -1; int act = 0; int exp = 0;
    for (int t = 0; t < 10; t++) begin
      for (int b = 0; b < 10; b++) begin
        if (allRdy[b] !== ((expLen[b] == 0) || (t >= expLen[b]))) begin
          if (ok) begin badT = t; act = allRdy; end
          ok = 0;
        end
      end
      if (ok) exp = 0;
      @(posedge clk); #1;
    end
    check(ok, req, $sformatf("ready window bad at t=%0d", badT), act, exp);
  endtask

  task automatic checkCounters(input string req);
    check(memInPipe == 8'(eMem), req, "memInPipe", memInPipe, eMem);
    check(glbRdInPipe == 8'(eGr) && glbWrInPipe == 8'(eGw), req, "glb rd/wr",
          {glbRdInPipe, glbWrInPipe}, {8'(eGr), 8'(eGw)});
    check(locRdInPipe == 8'(eLr) && locWrInPipe == 8'(eLw), req, "loc rd/wr",
          {locRdInPipe, locWrInPipe}, {8'(eLr), 8'(eLw)});
  endtask

  task automatic scenario(input logic [4:0] k, input int s, input logic [1:0] sp,
                          input string req);
    model(k, s, sp);
    drive(k, s, sp);
    window(req);
    checkCounters({req, " R9"});
  endtask

  task automatic test_reset();
    check(allRdy == 10'h3FF, "R1", "all ready after reset", allRdy, 10'h3FF);
    check(memInPipe == 0 && glbRdInPipe == 0 && glbWrInPipe == 0 &&
          locRdInPipe == 0 && locWrInPipe == 0, "R1", "counters zero", memInPipe, 0);
  endtask

  task automatic test_alu();
    for (int k = 1; k <= 6; k++) scenario(5'(k), k % 2, 2'd0, "R2");
  endtask

  task automatic test_barrier();
    scenario(5'd7, 1, 2'd0, "R3");
    scenario(5'd7, 0, 2'd0, "R3");
  endtask

  task automatic test_global();
    // round-robin across the global pool exercised here: R8
    scenario(5'd8, 0, 2'd0, "R4 R8");
    scenario(5'd9, 0, 2'd0, "R4 R8");
    scenario(5'd10, 1, 2'd0, "R4 R8");
    scenario(5'd14, 0, 2'd0, "R4 R8");
    scenario(5'd15, 0, 2'd0, "R4 R8");
    scenario(5'd16, 0, 2'd0, "R4 R8");
  endtask

  task automatic test_local();
    scenario(5'd11, 0, 2'd0, "R5 R8");
    scenario(5'd12, 0, 2'd0, "R5 R8");
    scenario(5'd13, 0, 2'd0, "R5 R8");
  endtask

  task automatic test_flat();
    scenario(5'd17, 0, 2'd2, "R6");
    scenario(5'd18, 0, 2'd1, "R6");
    scenario(5'd17, 0, 2'd3, "R6");
    scenario(5'd18, 0, 2'd2, "R6");
  endtask

  task automatic test_flat_none();
    model(5'd17, 0, 2'd0);
    @(negedge clk);
    issueValid = 1'b1; issueKind = 5'd17; issueSimd = 1'b0; flatSpace = 2'd0;
    #1;
    check(flatErr == 1'b1, "R7", "flatErr on unresolved flat", flatErr, 1);
    @(posedge clk); #1;
    issueValid = 1'b0;
    window("R7");
    checkCounters("R7");
    // pointer untouched: next global read must land on the expected bus
    scenario(5'd8, 0, 2'd0, "R7 R8");
  endtask

  task automatic test_nop();
    scenario(5'd0, 0, 2'd0, "R11");
    scenario(5'd25, 1, 2'd1, "R11");
    scenario(5'd31, 0, 2'd2, "R11");
    scenario(5'd8, 0, 2'd0, "R11 R8");
  endtask

  task automatic test_reload();
    int a; int n;
    a = gPtr;
    drive(5'd9, 0, 2'd0);
    drive(5'd9, 0, 2'd0);
    drive(5'd9, 0, 2'd0);
    eMem += 3; eGw += 3;
    n = 0;
    while (allRdy[6+a] == 1'b0 && n < 30) begin n++; @(posedge clk); #1; end
    check(n == 8, "R10", "bus held from reload edge", n, 8);
    check(gPtr == a, "R10", "start pointer sanity", gPtr, a);
    gPtr = (a + 1) % 2;
    repeat (10) @(posedge clk); #1;
    checkCounters("R10");
    scenario(5'd8, 0, 2'd0, "R10 R8");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    test_reset();
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    test_reset();
    test_alu();
    test_barrier();
    test_global();
    test_local();
    test_flat();
    test_flat_none();
    test_nop();
    test_reload();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule